// File: doc/BRIEF.md
# Flat Page Table Walker

This block resolves translation misses in hardware. When the translation cache has no entry for a virtual page, the miss is handed to the walker together with the page number. The walker takes the table root address from the base register of the running process. It forms the entry address by scaling the page number by the entry size and adding the root. It then issues one memory read and waits for the returned entry.

If the returned entry is marked valid, the walker drives a one-cycle fill toward the translation cache. The fill carries the physical page number and the entry's low attribute bits, with the accessed marker forced on. If the entry is marked invalid, the walker instead raises a one-cycle page-fault pulse that carries the page number. Only one walk is in flight at a time. A new miss is taken only when the walker is idle.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `miss_ready` is 1, and `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: A miss is accepted only on a clock edge where `miss_ready` is 1. A `miss_valid` seen while the walker is busy is ignored, and the completing fill or fault still reports the page number of the accepted miss.
- R3: The read address is (root + page number × 4) modulo 2^PA_W, for the default 32-bit entry. It is driven in the cycle after acceptance.
- R4: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with an unchanged address. The request drops in the cycle after the handshake.
- R5: An entry with bit 0 set produces `fill_valid` for one cycle, in the cycle after `mem_resp_valid`. The fill carries PPN = entry[OFF_W+PPN_W-1:OFF_W] and flags = entry[OFF_W-1:0] with bit 3, the accessed marker, set to 1.
- R6: An entry with bit 0 clear produces `fault_valid` for one cycle, in the cycle after `mem_resp_valid`, with `fault_vpn` equal to the missing page. No fill is made. Fill and fault are never asserted together.
- R7: `busy` is 1 from the cycle after acceptance through the fill or fault cycle. It is 0 in the cycle that follows, when `miss_ready` returns to 1.
- R8: A `mem_resp_valid` that arrives while no read is outstanding, including while the request still awaits its handshake, is ignored.
- R9: The root address is sampled when the miss is accepted. Later changes on `ptbr` do not alter the address of the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss offered |
| miss_vpn | input | VPN_W | Missing virtual page number |
| miss_ready | output | 1 | Walker idle, miss will be taken |
| busy | output | 1 | Walk in progress |
| ptbr | input | PA_W | Page table root of current process |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Entry data returned |
| mem_resp_data | input | PTE_W | Returned entry |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | VPN_W | Page number being filled |
| fill_ppn | output | PPN_W | Physical page number |
| fill_flags | output | OFF_W | Entry attributes, accessed bit set |
| fault_valid | output | 1 | Page fault pulse |
| fault_vpn | output | VPN_W | Faulting page number |

## Verification
Some properties are checked on every cycle: the request holds stable until its handshake, fill and fault never coincide, every fill carries the accessed bit, a response taken in the wait state leads to a fill or fault one cycle later, and each completion returns the walker to idle. The bench shows what depends on data and on the sequence of events. It sweeps every page number of a small configuration against two roots, one of which wraps the address space, and compares the computed address, PPN and flags with arithmetic expectations. The same sweeps show that a busy-time miss, a stray early response and a moved root leave the walk unaffected.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [2:0] {
      WK_IDLE  = 3'd0,
      WK_READ  = 3'd1,
      WK_WAIT  = 3'd2,
      WK_FILL  = 3'd3,
      WK_FAULT = 3'd4
   } walk_state_e;

   localparam int unsigned VALID_POS = 0;
   localparam int unsigned REF_POS   = 3;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned PTE_W = 32
) (
   input  logic [PA_W-1:0]  root,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  entry_addr
);
   localparam int unsigned BYTES = PTE_W / 8;
   localparam int unsigned SHIFT = $clog2(BYTES);
   localparam int unsigned SUM_W = PA_W + VPN_W + SHIFT;

   generate
      if ((PTE_W % 8) != 0 || (1 << SHIFT) != BYTES) begin : g_bad_pte
         $error("pgw_addr_gen: PTE_W must be a power-of-two byte count");
      end
   endgenerate

   logic [SUM_W-1:0] sum_w;
   logic [SUM_W-1:0] scaled_w;

   always_comb begin
      scaled_w   = SUM_W'(vpn) << SHIFT;
      sum_w      = SUM_W'(root) + scaled_w;
      entry_addr = sum_w[PA_W-1:0];
   end
endmodule

// File: rtl/pgw_pte_decode.sv
module pgw_pte_decode #(
   parameter int unsigned PTE_W   = 32,
   parameter int unsigned OFF_W   = 12,
   parameter int unsigned PPN_W   = 20,
   parameter bit          SET_REF = 1'b1
) (
   input  logic [PTE_W-1:0] pte,
   output logic             pte_valid,
   output logic [PPN_W-1:0] pte_ppn,
   output logic [OFF_W-1:0] pte_flags
);
   import pgw_pkg::*;

   generate
      if (OFF_W + PPN_W > PTE_W) begin : g_bad_fields
         $error("pgw_pte_decode: PPN and flag fields exceed entry width");
      end
      if (OFF_W <= REF_POS) begin : g_bad_off
         $error("pgw_pte_decode: flag field too narrow for accessed bit");
      end
   endgenerate

   logic [OFF_W-1:0] raw_flags;

   always_comb begin
      pte_valid = pte[VALID_POS];
      pte_ppn   = pte[OFF_W +: PPN_W];
      raw_flags = pte[OFF_W-1:0];
   end

   generate
      if (SET_REF) begin : g_mark_ref
         always_comb begin
            pte_flags          = raw_flags;
            pte_flags[REF_POS] = 1'b1;
         end
      end else begin : g_pass_ref
         always_comb pte_flags = raw_flags;
      end
   endgenerate
endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic mem_req_ready,
   input  logic mem_resp_valid,
   input  logic resp_pte_valid,
   output logic accept,
   output logic capture,
   output logic idle,
   output logic req_active,
   output logic fill_now,
   output logic fault_now
);
   import pgw_pkg::*;

   walk_state_e state_q, state_d;

   always_comb begin
      accept  = 1'b0;
      capture = 1'b0;
      state_d = state_q;
      unique case (state_q)
         WK_IDLE: if (miss_valid) begin
            accept  = 1'b1;
            state_d = WK_READ;
         end
         WK_READ: if (mem_req_ready) state_d = WK_WAIT;
         WK_WAIT: if (mem_resp_valid) begin
            capture = 1'b1;
            state_d = resp_pte_valid ? WK_FILL : WK_FAULT;
         end
         WK_FILL:  state_d = WK_IDLE;
         WK_FAULT: state_d = WK_IDLE;
         default:  state_d = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WK_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      idle       = (state_q == WK_IDLE);
      req_active = (state_q == WK_READ);
      fill_now   = (state_q == WK_FILL);
      fault_now  = (state_q == WK_FAULT);
   end

   // R7: an accepted miss leaves the walker non-idle next cycle
   p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !idle);
   // R5/R6: a captured response completes one cycle later
   p_resp_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (fill_now || fault_now));
   // R7: completion returns to idle
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_now || fault_now) |=> idle);
   // R8: capture only after a request has completed its handshake
   p_capture_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !req_active && !idle);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int unsigned VPN_W      = 20,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PTE_W      = 32,
   parameter int unsigned OFF_W      = 12,
   parameter int unsigned PPN_W      = 20,
   parameter bit          LATCH_ROOT = 1'b1,
   parameter bit          SET_REF    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [VPN_W-1:0] miss_vpn,
   output logic             miss_ready,
   output logic             busy,
   input  logic [PA_W-1:0]  ptbr,
   output logic             mem_req_valid,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_req_ready,
   input  logic             mem_resp_valid,
   input  logic [PTE_W-1:0] mem_resp_data,
   output logic             fill_valid,
   output logic [VPN_W-1:0] fill_vpn,
   output logic [PPN_W-1:0] fill_ppn,
   output logic [OFF_W-1:0] fill_flags,
   output logic             fault_valid,
   output logic [VPN_W-1:0] fault_vpn
);
   import pgw_pkg::*;

   generate
      if (VPN_W < 1 || PA_W < 8) begin : g_bad_widths
         $error("pgwalk_top: address widths too small");
      end
   endgenerate

   logic             accept, capture, idle, req_active, fill_now, fault_now;
   logic             dec_valid;
   logic [PPN_W-1:0] dec_ppn;
   logic [OFF_W-1:0] dec_flags;
   logic [VPN_W-1:0] vpn_q;
   logic [PA_W-1:0]  root_use;
   logic [PA_W-1:0]  addr_w;
   logic [PPN_W-1:0] ppn_q;
   logic [OFF_W-1:0] flags_q;

   pgw_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .miss_valid     (miss_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_resp_valid (mem_resp_valid),
      .resp_pte_valid (dec_valid),
      .accept         (accept),
      .capture        (capture),
      .idle           (idle),
      .req_active     (req_active),
      .fill_now       (fill_now),
      .fault_now      (fault_now)
   );

   pgw_pte_decode #(
      .PTE_W   (PTE_W),
      .OFF_W   (OFF_W),
      .PPN_W   (PPN_W),
      .SET_REF (SET_REF)
   ) u_dec (
      .pte       (mem_resp_data),
      .pte_valid (dec_valid),
      .pte_ppn   (dec_ppn),
      .pte_flags (dec_flags)
   );

   generate
      if (LATCH_ROOT) begin : g_root_latched
         logic [PA_W-1:0] root_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      root_q <= '0;
            else if (accept) root_q <= ptbr;
         end
         assign root_use = root_q;
      end else begin : g_root_live
         assign root_use = ptbr;
      end
   endgenerate

   pgw_addr_gen #(
      .VPN_W (VPN_W),
      .PA_W  (PA_W),
      .PTE_W (PTE_W)
   ) u_addr (
      .root       (root_use),
      .vpn        (vpn_q),
      .entry_addr (addr_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q   <= '0;
         ppn_q   <= '0;
         flags_q <= '0;
      end else begin
         if (accept)  vpn_q <= miss_vpn;
         if (capture) begin
            ppn_q   <= dec_ppn;
            flags_q <= dec_flags;
         end
      end
   end

   always_comb begin
      miss_ready    = idle;
      busy          = !idle;
      mem_req_valid = req_active;
      mem_req_addr  = addr_w;
      fill_valid    = fill_now;
      fill_vpn      = vpn_q;
      fill_ppn      = ppn_q;
      fill_flags    = flags_q;
      fault_valid   = fault_now;
      fault_vpn     = vpn_q;
   end

   // R4: request held with a stable address until handshake
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
   // R4: request drops after handshake
   p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
   // R6: fill and fault exclusive
   p_fill_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && fault_valid));
   // R5: accessed marker always set on a fill
   p_fill_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (!SET_REF || fill_flags[REF_POS]));
   // R2: page number stable while a walk is in progress
   p_vpn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fill_valid && !fault_valid) |=> $stable(fill_vpn));
endmodule

// File: tb/tb_pgwalk_top.sv
module tb_pgwalk_top;
   localparam int CLK_PERIOD = 10;
   localparam int VPN_W = 6;
   localparam int PA_W  = 16;
   localparam int PTE_W = 32;
   localparam int OFF_W = 12;
   localparam int PPN_W = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             miss_valid;
   logic [VPN_W-1:0] miss_vpn;
   logic             miss_ready, busy;
   logic [PA_W-1:0]  ptbr;
   logic             mem_req_valid;
   logic [PA_W-1:0]  mem_req_addr;
   logic             mem_req_ready;
   logic             mem_resp_valid;
   logic [PTE_W-1:0] mem_resp_data;
   logic             fill_valid;
   logic [VPN_W-1:0] fill_vpn;
   logic [PPN_W-1:0] fill_ppn;
   logic [OFF_W-1:0] fill_flags;
   logic             fault_valid;
   logic [VPN_W-1:0] fault_vpn;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwalk_top #(
      .VPN_W (VPN_W), .PA_W (PA_W), .PTE_W (PTE_W),
      .OFF_W (OFF_W), .PPN_W (PPN_W)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .miss_valid (miss_valid), .miss_vpn (miss_vpn),
      .miss_ready (miss_ready), .busy (busy), .ptbr (ptbr),
      .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
      .mem_req_ready (mem_req_ready), .mem_resp_valid (mem_resp_valid),
      .mem_resp_data (mem_resp_data),
      .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_ppn (fill_ppn),
      .fill_flags (fill_flags), .fault_valid (fault_valid), .fault_vpn (fault_vpn)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] entry_at(input logic [PA_W-1:0] a);
      logic [31:0] p;
      p = {a ^ 16'hA5C3, a[13:0], 2'b01};
      p[0] = a[2] ^ a[5] ^ a[9];
      p[3] = a[6];
      return p;
   endfunction

   task automatic walk(input logic [VPN_W-1:0] vpn, input logic [PA_W-1:0] root,
                       input int rd, input int rs);
      logic [PA_W-1:0] exp_addr;
      logic [31:0]     e;
      logic [OFF_W-1:0] exp_flags;
      exp_addr  = PA_W'(root + (PA_W'(vpn) << 2));
      e         = entry_at(exp_addr);
      exp_flags = e[OFF_W-1:0] | 12'h008;

      chk(miss_ready == 1'b1, "R7 ready before miss", miss_ready, 1);
      miss_valid = 1'b1; miss_vpn = vpn; ptbr = root;
      @(posedge clk); @(negedge clk);
      miss_valid = 1'b0; ptbr = ~root;                      // R9 root moves
      chk(mem_req_valid == 1'b1, "R3 request raised", mem_req_valid, 1);
      chk(mem_req_addr == exp_addr, "R3/R9 entry address", mem_req_addr, exp_addr);
      chk(busy == 1'b1, "R7 busy after accept", busy, 1);
      for (int i = 0; i < rd; i++) begin
         if (i == 0) begin                                  // R8 stray response
            mem_resp_valid = 1'b1; mem_resp_data = ~e;
         end
         @(posedge clk); @(negedge clk);
         mem_resp_valid = 1'b0;
         chk(mem_req_valid && mem_req_addr == exp_addr, "R4 request held",
             mem_req_addr, exp_addr);
         chk(!fill_valid && !fault_valid, "R8 stray response ignored",
             {fill_valid, fault_valid}, 0);
      end
      mem_req_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, "R4 request dropped", mem_req_valid, 0);
      for (int i = 0; i < rs; i++) begin
         miss_valid = 1'b1; miss_vpn = vpn ^ 6'd1;          // R2 busy miss
         @(posedge clk); @(negedge clk);
         chk(busy == 1'b1, "R7 busy while waiting", busy, 1);
      end
      miss_valid = 1'b1; miss_vpn = vpn ^ 6'd2;
      mem_resp_valid = 1'b1; mem_resp_data = e;
      @(posedge clk); @(negedge clk);
      mem_resp_valid = 1'b0; miss_valid = 1'b0;
      chk(busy == 1'b1, "R7 busy in completion cycle", busy, 1);
      if (e[0]) begin
         chk(fill_valid == 1'b1 && fault_valid == 1'b0, "R5 fill pulse",
             {fill_valid, fault_valid}, 2'b10);
         chk(fill_vpn == vpn, "R2 fill page number", fill_vpn, vpn);
         chk(fill_ppn == e[OFF_W +: PPN_W], "R5 fill ppn", fill_ppn, e[OFF_W +: PPN_W]);
         chk(fill_flags == exp_flags, "R5 fill flags", fill_flags, exp_flags);
      end else begin
         chk(fault_valid == 1'b1 && fill_valid == 1'b0, "R6 fault pulse",
             {fill_valid, fault_valid}, 2'b01);
         chk(fault_vpn == vpn, "R6 fault page number", fault_vpn, vpn);
      end
      @(posedge clk); @(negedge clk);
      chk(!busy && miss_ready && !fill_valid && !fault_valid && !mem_req_valid,
          "R7 idle after completion", {busy, fill_valid, fault_valid}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; miss_valid = 1'b0; miss_vpn = '0; ptbr = '0;
      mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(miss_ready && !busy && !mem_req_valid && !fill_valid && !fault_valid,
          "R1 reset state", {miss_ready, busy, mem_req_valid, fill_valid, fault_valid},
          5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: response while idle has no effect
      mem_resp_valid = 1'b1; mem_resp_data = 32'hFFFF_FFFF;
      @(posedge clk); @(negedge clk);
      mem_resp_valid = 1'b0;
      chk(!busy && !fill_valid && !fault_valid, "R8 idle response ignored",
          {busy, fill_valid, fault_valid}, 0);
      for (int b = 0; b < 2; b++) begin
         for (int v = 0; v < (1 << VPN_W); v++) begin
            walk(VPN_W'(v), (b == 0) ? 16'h1000 : 16'hFF80, v % 3, (v / 3) % 3);
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule